// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block combines every reset request of a chip into one system reset line. It also records which source caused the reset in a status register that software can clear. It accepts two power-related requests, a power-on pulse and a brown-out pulse, and treats both as cold resets. It accepts four warm requests: an active-low external reset pin, a watchdog timeout, a software reset strobe and a configuration-mismatch strobe. A low-power indicator tells the block that the device is in sleep or idle.

The external pin passes through a synchronizer and then a pulse-width filter, so short glitches never reach the reset line. The asynchronous sources drive the reset line directly and without a clock. The watchdog does the same, except in low power, where its timeout becomes a wake request. Release of the reset is always synchronous and is stretched by a fixed number of cycles. A software strobe gives exactly one cycle of reset.

Top module: `rstgen_top`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` is high. After power-on, `status_o` reads 0x001 (bit 0 = power-on) and `cold_o` is 1.
- R2: A brown-out asserts `sys_rst_o` at once, including while `lowpwr_i` is high. It sets status bit 1, clears the warm bits 4, 6, 7 and 9, and sets `cold_o`.
- R3: The pin goes through a 2-flop synchronizer. A low level sampled on N consecutive clock edges causes a reset only if N >= MIN_LOW_CYCLES (default 4). Shorter pulses leave `sys_rst_o` low and status bit 7 clear.
- R4: A pin pulse that qualifies raises `sys_rst_o` after the (MIN_LOW_CYCLES+2)-th edge, counting the first edge that samples the low level as edge 1. `sys_rst_o` stays high for N-MIN_LOW_CYCLES+1+HOLD_CYCLES cycles, and status bit 7 is set.
- R5: A watchdog timeout with `lowpwr_i` low asserts `sys_rst_o` in the same cycle without a clock edge, and sets status bit 4.
- R6: A watchdog timeout with `lowpwr_i` high drives `wake_o` high and leaves `sys_rst_o` low, yet still sets status bit 4.
- R7: A software strobe that is high on one clock edge gives `sys_rst_o` high for exactly the following cycle, with no stretch, and sets status bit 6.
- R8: A configuration-mismatch strobe asserts `sys_rst_o` in the same cycle and sets status bit 9.
- R9: After the last of the power-on, brown-out, watchdog, pin and mismatch requests falls, `sys_rst_o` stays high for exactly HOLD_CYCLES (default 2) more cycles. This count includes the partial cycle in which the request fell.
- R10: A write with `stat_clr_we_i` high clears each status bit whose `stat_clr_i` bit is 1 and leaves the others unchanged. A source event in the same cycle wins over the clear.
- R11: `cold_o` falls to 0 on any warm reset event (pin, watchdog reset, software or mismatch) and rises to 1 on a brown-out.
- R12: Without a clear write and without a cold event, a set status bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| bor_i | input | 1 | Brown-out pulse, active high |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdt_tmo_i | input | 1 | Watchdog timeout |
| sw_rst_i | input | 1 | Software reset strobe |
| cfg_mm_i | input | 1 | Configuration-mismatch strobe |
| lowpwr_i | input | 1 | Device is in sleep or idle |
| stat_clr_we_i | input | 1 | Status clear write enable |
| stat_clr_i | input | 10 | Write-1-to-clear mask |
| sys_rst_o | output | 1 | System reset, active high |
| wake_o | output | 1 | Wake request from a watchdog timeout in low power |
| cold_o | output | 1 | Last reset was cold |
| status_o | output | 10 | Sticky reset-cause flags |

## Verification
A hold counter that is off by one shows up at `sys_rst_o` within two cycles of any request falling, as a release that comes one cycle early or one cycle late. A filter counter that saturates at the wrong value shows up when the pin pulse is swept across the threshold: a pulse one cycle shorter than the threshold resets the device, or one at the threshold does not. The first-rise cycle and the width of the reset window expose this within MIN_LOW_CYCLES+2 edges. A fault in the set, clear or cold-wipe logic of the status register appears on `status_o` one edge after the event.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  localparam int STAT_W = 10;
  localparam int B_POR  = 0;
  localparam int B_BOR  = 1;
  localparam int B_WDT  = 4;
  localparam int B_SW   = 6;
  localparam int B_PIN  = 7;
  localparam int B_CM   = 9;

  localparam logic [STAT_W-1:0] WARM_MASK =
    STAT_W'((1 << B_WDT) | (1 << B_SW) | (1 << B_PIN) | (1 << B_CM));
  localparam logic [STAT_W-1:0] POR_VAL = STAT_W'(1 << B_POR);

  // Next status value: clear first, then a cold event wipes warm flags
  // and sets its own flag; otherwise warm flags are OR-ed in.
  function automatic logic [STAT_W-1:0] stat_next(
    input logic [STAT_W-1:0] cur,
    input logic [STAT_W-1:0] clr,
    input logic [STAT_W-1:0] cold_set,
    input logic [STAT_W-1:0] warm_set
  );
    logic [STAT_W-1:0] v;
    v = cur & ~clr;
    if (|cold_set) v = (v & ~WARM_MASK) | cold_set;
    else           v = v | warm_set;
    return v;
  endfunction
endpackage

// File: rtl/rstgen_pin_filter.sv
module rstgen_pin_filter #(
  parameter int SYNC_STAGES    = 2,
  parameter int MIN_LOW_CYCLES = 4
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic pin_n_i,
  output logic req_o
);
  localparam int CW = $clog2(MIN_LOW_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_LOW_CYCLES);

  function automatic logic [CW-1:0] low_step(input logic [CW-1:0] c, input logic pin_low);
    if (!pin_low)     return '0;
    else if (c < CMAX) return c + 1'b1;
    else              return c;
  endfunction

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_sync;
  logic [CW-1:0]          low_cnt;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) sync_q <= '1;
    else       sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n_i};
  end

  assign pin_sync = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) low_cnt <= '0;
    else       low_cnt <= low_step(low_cnt, !pin_sync);
  end

  assign req_o = (low_cnt == CMAX);

  // R3: a request only appears after a low synchronized sample
  assert_pin_width_R3: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(req_o) |-> !$past(pin_sync));
endmodule

// File: rtl/rstgen_hold.sv
module rstgen_hold #(
  parameter int HOLD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic src_i,
  output logic active_o
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HW-1:0] HMAX = HW'(HOLD_CYCLES);

  function automatic logic [HW-1:0] hold_step(input logic [HW-1:0] c, input logic src);
    if (src)          return HMAX;
    else if (c != '0) return c - 1'b1;
    else              return c;
  endfunction

  logic [HW-1:0] cnt;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) cnt <= HMAX;
    else       cnt <= hold_step(cnt, src_i);
  end

  assign active_o = (cnt != '0);

  // R9: the stretch ends only after the sources were quiet
  assert_hold_release_R9: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(active_o) |-> !$past(src_i));
endmodule

// File: rtl/rstgen_status.sv
module rstgen_status
  import rstgen_pkg::*;
(
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              clr_we_i,
  input  logic [STAT_W-1:0] clr_i,
  input  logic [STAT_W-1:0] cold_set_i,
  input  logic [STAT_W-1:0] warm_set_i,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W-1:0] clr_eff;
  assign clr_eff = clr_we_i ? clr_i : '0;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) status_o <= POR_VAL;
    else       status_o <= stat_next(status_o, clr_eff, cold_set_i, warm_set_i);
  end

  assert_cold_wipe_R2: assert property (@(posedge clk_i) disable iff (por_i)
    (|cold_set_i) |=> ((status_o & WARM_MASK) == '0));

  assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (por_i)
    (!(|cold_set_i)) |=> ((status_o & $past(warm_set_i)) == $past(warm_set_i)));

  assert_sticky_R12: assert property (@(posedge clk_i) disable iff (por_i)
    (!clr_we_i && !(|cold_set_i)) |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
  import rstgen_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int MIN_LOW_CYCLES = 4,
  parameter int HOLD_CYCLES    = 2
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              bor_i,
  input  logic              ext_rst_n_i,
  input  logic              wdt_tmo_i,
  input  logic              sw_rst_i,
  input  logic              cfg_mm_i,
  input  logic              lowpwr_i,
  input  logic              stat_clr_we_i,
  input  logic [STAT_W-1:0] stat_clr_i,
  output logic              sys_rst_o,
  output logic              wake_o,
  output logic              cold_o,
  output logic [STAT_W-1:0] status_o
);
  logic pin_req;
  logic wdt_rst;
  logic src_now;
  logic hold_active;
  logic sw_q;
  logic warm_evt;
  logic [STAT_W-1:0] cold_set;
  logic [STAT_W-1:0] warm_set;

  rstgen_pin_filter #(
    .SYNC_STAGES   (SYNC_STAGES),
    .MIN_LOW_CYCLES(MIN_LOW_CYCLES)
  ) u_pin (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .pin_n_i(ext_rst_n_i),
    .req_o  (pin_req)
  );

  assign wdt_rst = wdt_tmo_i & ~lowpwr_i;
  assign wake_o  = wdt_tmo_i & lowpwr_i;
  assign src_now = por_i | bor_i | wdt_rst | pin_req | cfg_mm_i;

  rstgen_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i   (clk_i),
    .por_i   (por_i),
    .src_i   (src_now),
    .active_o(hold_active)
  );

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) sw_q <= 1'b0;
    else       sw_q <= sw_rst_i;
  end

  assign sys_rst_o = src_now | hold_active | sw_q;

  assign warm_evt = wdt_rst | pin_req | sw_rst_i | cfg_mm_i;

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i)         cold_o <= 1'b1;
    else if (bor_i)    cold_o <= 1'b1;
    else if (warm_evt) cold_o <= 1'b0;
  end

  always_comb begin
    cold_set        = '0;
    cold_set[B_BOR] = bor_i;
    warm_set        = '0;
    warm_set[B_WDT] = wdt_tmo_i;
    warm_set[B_SW]  = sw_rst_i;
    warm_set[B_PIN] = pin_req;
    warm_set[B_CM]  = cfg_mm_i;
  end

  rstgen_status u_stat (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .clr_we_i  (stat_clr_we_i),
    .clr_i     (stat_clr_i),
    .cold_set_i(cold_set),
    .warm_set_i(warm_set),
    .status_o  (status_o)
  );

  assert_sw_one_cycle_R7: assert property (@(posedge clk_i) disable iff (por_i)
    sw_rst_i |=> sys_rst_o);

  assert_wake_no_reset_R6: assert property (@(posedge clk_i) disable iff (por_i)
    (wake_o && !bor_i && !cfg_mm_i && !pin_req && !hold_active && !sw_q) |-> !sys_rst_o);

  assert_warm_clears_cold_R11: assert property (@(posedge clk_i) disable iff (por_i)
    (warm_evt && !bor_i) |=> !cold_o);
endmodule

// File: tb/rstgen_top_tb.sv
module rstgen_top_tb;
  localparam int MIN  = 4;
  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic por = 1'b1, bor = 1'b0, pin_n = 1'b1, wdt = 1'b0, sw = 1'b0, cm = 1'b0, lp = 1'b0;
  logic clr_we = 1'b0;
  logic [9:0] clr = '0;
  logic sys_rst, wake, cold;
  logic [9:0] status;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rstgen_top #(.MIN_LOW_CYCLES(MIN), .HOLD_CYCLES(HOLD)) u_dut (
    .clk_i(clk), .por_i(por), .bor_i(bor), .ext_rst_n_i(pin_n),
    .wdt_tmo_i(wdt), .sw_rst_i(sw), .cfg_mm_i(cm), .lowpwr_i(lp),
    .stat_clr_we_i(clr_we), .stat_clr_i(clr),
    .sys_rst_o(sys_rst), .wake_o(wake), .cold_o(cold), .status_o(status)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr = '1;
    step();
    clr_we = 1'b0; clr = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1;
    // R1: power-on
    chk("R1 rst during por", int'(sys_rst), 1);
    step(); step(); step();
    chk("R1 status after por", int'(status), 'h001);
    chk("R1 cold after por", int'(cold), 1);
    por = 1'b0;
    // R9: release stretch after por
    chk("R9 held cycle0", int'(sys_rst), 1);
    step();
    chk("R9 held cycle1", int'(sys_rst), 1);
    step();
    chk("R9 released", int'(sys_rst), 0);

    // R3/R4: pin pulse width sweep
    for (int n = 1; n <= 7; n++) begin
      int first;
      int cnt;
      clear_all();
      first = 0; cnt = 0;
      pin_n = 1'b0;
      for (int s = 1; s <= n + 8; s++) begin
        step();
        if (s == n) pin_n = 1'b1;
        if (sys_rst && first == 0) first = s;
        if (sys_rst) cnt++;
      end
      if (n >= MIN) begin
        chk("R4 first reset edge", first, MIN + 2);
        chk("R4 reset width", cnt, n - MIN + 1 + HOLD);
        chk("R4 status pin bit7", int'(status[7]), 1);
      end else begin
        chk("R3 short pulse no reset", cnt, 0);
        chk("R3 short pulse no bit7", int'(status[7]), 0);
      end
    end
    chk("R11 cold low after pin reset", int'(cold), 0);

    // R5: watchdog outside low power
    clear_all();
    wdt = 1'b1; #1;
    chk("R5 async assert", int'(sys_rst), 1);
    step(); wdt = 1'b0; #1;
    chk("R5 status bit4", int'(status), 'h010);
    chk("R9 wdt held0", int'(sys_rst), 1);
    step();
    chk("R9 wdt held1", int'(sys_rst), 1);
    step();
    chk("R9 wdt released", int'(sys_rst), 0);

    // R7: software strobe
    sw = 1'b1; #1;
    chk("R7 no reset before edge", int'(sys_rst), 0);
    step(); sw = 1'b0; #1;
    chk("R7 reset next cycle", int'(sys_rst), 1);
    chk("R7 status bit6", int'(status), 'h050);
    step();
    chk("R7 single cycle", int'(sys_rst), 0);

    // R8: configuration mismatch
    cm = 1'b1; #1;
    chk("R8 async assert", int'(sys_rst), 1);
    step(); cm = 1'b0; #1;
    chk("R8 status bit9", int'(status), 'h250);
    step(); step();
    chk("R8 released", int'(sys_rst), 0);

    // R6: watchdog in low power
    lp = 1'b1; wdt = 1'b1; #1;
    chk("R6 wake", int'(wake), 1);
    chk("R6 no reset", int'(sys_rst), 0);
    step(); wdt = 1'b0; #1;
    chk("R6 still no reset", int'(sys_rst), 0);
    chk("R6 wake drops", int'(wake), 0);
    chk("R6 status bit4", int'(status[4]), 1);

    // R12: sticky without clear
    step(); step();
    chk("R12 sticky", int'(status), 'h250);

    // R10: zero-write leaves bits
    clr_we = 1'b1; clr = '0;
    step(); clr_we = 1'b0;
    chk("R10 zero mask no effect", int'(status), 'h250);

    // R2: brown-out in low power
    bor = 1'b1; #1;
    chk("R2 async in low power", int'(sys_rst), 1);
    step(); bor = 1'b0; #1;
    chk("R2 status wiped", int'(status), 'h002);
    chk("R2 cold set", int'(cold), 1);
    step(); step();
    chk("R2 released", int'(sys_rst), 0);
    lp = 1'b0;

    // R10: set wins over clear; other bits clear
    sw = 1'b1; clr_we = 1'b1; clr = 10'h042;
    step(); sw = 1'b0; clr_we = 1'b0; clr = '0;
    chk("R10 set wins, bit1 cleared", int'(status), 'h040);
    chk("R11 cold low after sw", int'(cold), 0);
    step();
    clr_we = 1'b1; clr = 10'h040;
    step(); clr_we = 1'b0; clr = '0;
    chk("R10 w1c", int'(status), 'h000);

    finish_run();
  end
endmodule